// File: doc/BRIEF.md
# Byte-Wide UV EPROM Behavioural Model

This block is a synthesizable model of a byte-wide ultraviolet-erasable programmable read-only memory. It can act as a memory target in a testbench or in an emulation build. The control inputs are active-low: a chip select that doubles as the program strobe, and an output enable. Three level flags stand for analog conditions: programming voltage on the output-enable pin, a raised supply, and high voltage on address bit 9. From these inputs the block decodes which operating mode applies. It then drives the stored byte, a signature byte, or nothing.

A blank byte reads 0xFF. Programming can only clear bits. A new value is the old byte ANDed with the presented data. Only the bulk erase input can set bits back to 1. Erase sweeps the array over several clock cycles, and a busy flag is high for the whole sweep. Reads are combinational from the inputs, so results appear in the same cycle. Programming happens on a clock edge, once for each strobe pulse. Analog levels and access delays are not modelled. The array depth is 2^ADDR_W bytes, with a default of 1024.

Top module: `eprom_model`

## Requirements
- R1: With ce_n=0, oe_n=0 and vpp_on_oe, vcc_hi and a9_hv all 0, dout_oe is 1 and dout is the stored byte at addr, in the same cycle.
- R2: With oe_n=1 and vpp_on_oe=0, dout_oe is 0 whatever ce_n is.
- R3: With ce_n=1, dout_oe is 0 whatever oe_n and the voltage flags are.
- R4: With vpp_on_oe=1, vcc_hi=1 and a9_hv=0, a low pulse on ce_n programs the byte once. The write lands on the first clock edge after ce_n returns high. It uses the address and data present in the last cycle ce_n was low. Holding ce_n low writes nothing until release, and dout_oe stays 0 throughout.
- R5: With vcc_hi=1, vpp_on_oe=0, a9_hv=0 and both enables low (verify), dout_oe is 1 and dout is the stored byte.
- R6: A program writes old AND data: bits presented as 1 leave the stored bit unchanged, and a 0 can never become 1 through programming.
- R7: With a9_hv=1, both enables low, vpp_on_oe=0, vcc_hi=0 and addr[ADDR_W-1:1]=0, dout is 0x8F when addr[0]=0 and 0x85 when addr[0]=1, with dout_oe=1.
- R8: erase_req high at a clock edge while erase_busy is 0 raises erase_busy for exactly 2^ADDR_W/ERASE_LANES cycles. After that, every byte reads 0xFF.
- R9: While erase_busy is 1, dout_oe is 0, strobe pulses program nothing, and further erase_req pulses do not lengthen the sweep.
- R10: These combinations are illegal: vpp_on_oe=1 with vcc_hi=0; a9_hv=1 together with vpp_on_oe or vcc_hi; a9_hv=1 in a read with any of addr[ADDR_W-1:1] set. In an illegal combination outputs are undriven and the array is unchanged.
- R11: After reset every byte reads 0xFF and erase_busy is 0.
- R12: Whenever dout_oe is 0, dout is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; the array becomes blank |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Data presented for programming |
| ce_n | input | 1 | Chip select and program strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| vpp_on_oe | input | 1 | Programming voltage present on the output-enable pin |
| vcc_hi | input | 1 | Raised programming supply present |
| a9_hv | input | 1 | High voltage on address bit 9 (signature access) |
| erase_req | input | 1 | Starts a bulk erase |
| dout | output | 8 | Read data, 0x00 when not driven |
| dout_oe | output | 1 | Output drive enable |
| erase_busy | output | 1 | Erase sweep in progress |

## Verification
Some properties are asserted on every cycle. Outputs stay undriven in standby, in output disable, in illegal combinations and during erase. The strobe fires at most once per release and never while erase runs or when the supply is not raised. Normal reads drive the outputs, the two signature bytes come out for their addresses, and each erase lasts exactly its sweep length. Other behaviour only the bench scenarios can show, by comparing against a bench-side shadow array under random mode sequences. These cover AND-only programming, use of the final address and data of a long strobe, blank contents after reset and after erase, and untouched bytes after illegal or busy-time strobes.

// File: rtl/eprom_pkg.sv
package eprom_pkg;

  typedef enum logic [3:0] {
    MODE_READ,
    MODE_OUT_DIS,
    MODE_STANDBY,
    MODE_PROG,
    MODE_VERIFY,
    MODE_INHIBIT,
    MODE_SIGNATURE,
    MODE_ERASING,
    MODE_ILLEGAL
  } mode_t;

  // Mode map; priority: erase, high voltage on OE, select, output enable, signature.
  function automatic mode_t decode_mode(
    input logic busy,
    input logic ce_n,
    input logic oe_n,
    input logic vpp,
    input logic vcc_hi,
    input logic a9_hv,
    input logic upper_zero
  );
    mode_t m;
    if (busy)                      m = MODE_ERASING;
    else if (vpp) begin
      if (!vcc_hi || a9_hv)        m = MODE_ILLEGAL;
      else if (ce_n)               m = MODE_INHIBIT;
      else                         m = MODE_PROG;
    end
    else if (ce_n)                 m = MODE_STANDBY;
    else if (oe_n)                 m = MODE_OUT_DIS;
    else if (a9_hv) begin
      if (vcc_hi || !upper_zero)   m = MODE_ILLEGAL;
      else                         m = MODE_SIGNATURE;
    end
    else if (vcc_hi)               m = MODE_VERIFY;
    else                           m = MODE_READ;
    return m;
  endfunction

  // Cells can only be pulled from 1 to 0 by programming.
  function automatic logic [7:0] prog_merge(input logic [7:0] old_b, input logic [7:0] new_b);
    return old_b & new_b;
  endfunction

  function automatic logic [7:0] sig_byte(input logic sel, input logic [7:0] mfr, input logic [7:0] dev);
    return sel ? dev : mfr;
  endfunction

endpackage

// File: rtl/eprom_mode_dec.sv
module eprom_mode_dec
  import eprom_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              busy,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              vpp,
  input  logic              vcc_hi,
  input  logic              a9_hv,
  input  logic [ADDR_W-1:0] addr,
  output mode_t             mode
);
  logic upper_zero;
  assign upper_zero = (addr[ADDR_W-1:1] == '0);

  always_comb mode = decode_mode(busy, ce_n, oe_n, vpp, vcc_hi, a9_hv, upper_zero);
endmodule

// File: rtl/eprom_prog_pulse.sv
module eprom_prog_pulse
  import eprom_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  mode_t             mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic              prog_fire,
  output logic [ADDR_W-1:0] waddr,
  output logic [7:0]        wdata
);
  logic in_pulse_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_pulse_q <= 1'b0;
      waddr      <= '0;
      wdata      <= '0;
    end else begin
      in_pulse_q <= (mode == MODE_PROG);
      if (mode == MODE_PROG) begin
        waddr <= addr;
        wdata <= din;
      end
    end
  end

  // Rising strobe with the programming conditions still valid.
  assign prog_fire = in_pulse_q && (mode == MODE_INHIBIT);
endmodule

// File: rtl/eprom_erase_seq.sv
module eprom_erase_seq #(
  parameter int ADDR_W      = 10,
  parameter int ERASE_LANES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              erase_req,
  output logic              busy,
  output logic [ADDR_W-1:0] base
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int NCYC   = DEPTH / ERASE_LANES;
  localparam int CNT_W  = (NCYC > 1) ? $clog2(NCYC) : 1;
  localparam int LANE_W = $clog2(ERASE_LANES);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (!busy) begin
      if (erase_req) begin
        busy <= 1'b1;
        cnt  <= '0;
      end
    end else begin
      cnt <= cnt + 1'b1;
      if (cnt == CNT_W'(NCYC - 1)) busy <= 1'b0;
    end
  end

  generate
    if (ERASE_LANES == 1) begin : g_single
      assign base = ADDR_W'(cnt);
    end else begin : g_multi
      assign base = {cnt[ADDR_W-LANE_W-1:0], {LANE_W{1'b0}}};
    end
  endgenerate
endmodule

// File: rtl/eprom_array.sv
module eprom_array
  import eprom_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int ERASE_LANES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              erase_busy,
  input  logic [ADDR_W-1:0] erase_base,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (erase_busy) begin
      for (int l = 0; l < ERASE_LANES; l++) mem[erase_base + ADDR_W'(l)] <= 8'hFF;
    end else if (wr_en) begin
      mem[waddr] <= prog_merge(mem[waddr], wdata);
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/eprom_model.sv
module eprom_model
  import eprom_pkg::*;
#(
  parameter int         ADDR_W      = 10,
  parameter int         ERASE_LANES = 4,
  parameter logic [7:0] MFR_CODE    = 8'h8F,
  parameter logic [7:0] DEV_CODE    = 8'h85
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              vpp_on_oe,
  input  logic              vcc_hi,
  input  logic              a9_hv,
  input  logic              erase_req,
  output logic [7:0]        dout,
  output logic              dout_oe,
  output logic              erase_busy
);
  mode_t             mode;
  logic              prog_fire;
  logic [ADDR_W-1:0] waddr;
  logic [7:0]        wdata;
  logic [ADDR_W-1:0] erase_base;
  logic [7:0]        rdata;
  logic              drive;
  logic [7:0]        out_byte;

  eprom_mode_dec #(.ADDR_W(ADDR_W)) dec_i (
    .busy(erase_busy), .ce_n(ce_n), .oe_n(oe_n), .vpp(vpp_on_oe),
    .vcc_hi(vcc_hi), .a9_hv(a9_hv), .addr(addr), .mode(mode)
  );

  eprom_prog_pulse #(.ADDR_W(ADDR_W)) pulse_i (
    .clk(clk), .rst_n(rst_n), .mode(mode), .addr(addr), .din(din),
    .prog_fire(prog_fire), .waddr(waddr), .wdata(wdata)
  );

  eprom_erase_seq #(.ADDR_W(ADDR_W), .ERASE_LANES(ERASE_LANES)) erase_i (
    .clk(clk), .rst_n(rst_n), .erase_req(erase_req),
    .busy(erase_busy), .base(erase_base)
  );

  eprom_array #(.ADDR_W(ADDR_W), .ERASE_LANES(ERASE_LANES)) array_i (
    .clk(clk), .rst_n(rst_n), .erase_busy(erase_busy), .erase_base(erase_base),
    .wr_en(prog_fire), .waddr(waddr), .wdata(wdata), .raddr(addr), .rdata(rdata)
  );

  assign drive    = (mode == MODE_READ) || (mode == MODE_VERIFY) || (mode == MODE_SIGNATURE);
  assign out_byte = (mode == MODE_SIGNATURE) ? sig_byte(addr[0], MFR_CODE, DEV_CODE) : rdata;
  assign dout_oe  = drive;
  assign dout     = drive ? out_byte : 8'h00;
endmodule

// File: rtl/eprom_model_chk.sv
module eprom_model_chk #(
  parameter int         ADDR_W      = 10,
  parameter int         ERASE_LANES = 4,
  parameter logic [7:0] MFR_CODE    = 8'h8F,
  parameter logic [7:0] DEV_CODE    = 8'h85
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              ce_n,
  input logic              oe_n,
  input logic              vpp_on_oe,
  input logic              vcc_hi,
  input logic              a9_hv,
  input logic [7:0]        dout,
  input logic              dout_oe,
  input logic              erase_busy,
  input logic              prog_fire
);
  localparam int NCYC  = (1 << ADDR_W) / ERASE_LANES;
  localparam int BCW   = $clog2(NCYC + 1) + 1;

  logic [BCW-1:0] bcnt;
  logic           sig_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bcnt <= '0;
    else        bcnt <= erase_busy ? bcnt + 1'b1 : '0;
  end

  assign sig_sel = !ce_n && !oe_n && !vpp_on_oe && !vcc_hi && a9_hv && !erase_busy
                   && (addr[ADDR_W-1:1] == '0);

  // R1
  read_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !oe_n && !vpp_on_oe && !vcc_hi && !a9_hv && !erase_busy) |-> dout_oe);

  // R2
  out_dis_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_n && !vpp_on_oe) |-> !dout_oe);

  // R3
  standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> !dout_oe);

  // R4
  fire_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_fire |=> !prog_fire);

  // R4
  fire_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_fire |-> (ce_n && vpp_on_oe && vcc_hi && !a9_hv && !dout_oe));

  // R7
  sig_mfr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sig_sel && !addr[0]) |-> (dout_oe && dout == MFR_CODE));

  // R7
  sig_dev_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sig_sel && addr[0]) |-> (dout_oe && dout == DEV_CODE));

  // R8
  erase_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(erase_busy)) |-> (bcnt == BCW'(NCYC)));

  // R8
  erase_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bcnt <= BCW'(NCYC));

  // R9
  busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_busy |-> (!dout_oe && !prog_fire));

  // R10
  illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((vpp_on_oe && !vcc_hi) || (a9_hv && (vpp_on_oe || vcc_hi))) |-> (!dout_oe && !prog_fire));

  // R12
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_oe |-> (dout == 8'h00));
endmodule

bind eprom_model eprom_model_chk #(
  .ADDR_W(ADDR_W), .ERASE_LANES(ERASE_LANES), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)
) chk_i (
  .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .oe_n(oe_n),
  .vpp_on_oe(vpp_on_oe), .vcc_hi(vcc_hi), .a9_hv(a9_hv), .dout(dout),
  .dout_oe(dout_oe), .erase_busy(erase_busy), .prog_fire(prog_fire)
);

// File: tb/eprom_model_tb_top.sv
module eprom_model_tb_top;
  localparam int AW    = 10;
  localparam int LANES = 4;
  localparam int DEPTH = 1 << AW;
  localparam int NCYC  = DEPTH / LANES;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    din = '0;
  logic          ce_n = 1'b1, oe_n = 1'b1, vpp_on_oe = 1'b0, vcc_hi = 1'b0, a9_hv = 1'b0;
  logic          erase_req = 1'b0;
  logic [7:0]    dout;
  logic          dout_oe, erase_busy;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  logic [7:0] shadow [DEPTH];

  always #4 clk = ~clk;

  eprom_model #(.ADDR_W(AW), .ERASE_LANES(LANES)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .din(din), .ce_n(ce_n), .oe_n(oe_n),
    .vpp_on_oe(vpp_on_oe), .vcc_hi(vcc_hi), .a9_hv(a9_hv), .erase_req(erase_req),
    .dout(dout), .dout_oe(dout_oe), .erase_busy(erase_busy)
  );

  function automatic bit exp_drive(bit c, bit o, bit vp, bit vh, bit hv, logic [AW-1:0] a);
    if (vp || c || o) return 1'b0;
    if (hv) return !vh && ((a >> 1) == 0);
    return 1'b1;
  endfunction

  function automatic logic [7:0] exp_byte(bit hv, logic [AW-1:0] a);
    if (hv) return a[0] ? 8'h85 : 8'h8F;
    return shadow[a];
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic nxt();
    @(negedge clk);
  endtask

  task automatic idle();
    ce_n = 1; oe_n = 1; vpp_on_oe = 0; vcc_hi = 0; a9_hv = 0; erase_req = 0;
  endtask

  task automatic read_chk(input logic [AW-1:0] a, input logic [7:0] e, input string tag);
    nxt();
    idle(); ce_n = 0; oe_n = 0; addr = a;
    #1;
    chk(dout_oe === 1'b1 && dout === e, tag, {dout_oe, dout}, {1'b1, e});
  endtask

  task automatic prog_pulse(input logic [AW-1:0] a, input logic [7:0] d, input int hold, input bit hi);
    nxt();
    idle(); vpp_on_oe = 1; vcc_hi = hi; addr = a; din = d;
    nxt();
    ce_n = 0;
    repeat (hold) nxt();
    ce_n = 1;
    nxt();
    idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) shadow[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R11 / R3 / R12 reset state
    nxt(); #1;
    chk(erase_busy === 1'b0, "R11 busy after reset", erase_busy, 0);
    chk(dout_oe === 1'b0, "R3 standby after reset", dout_oe, 0);
    chk(dout === 8'h00, "R12 idle dout", dout, 0);
    read_chk(0, 8'hFF, "R11 blank addr 0");
    read_chk(10'h3FF, 8'hFF, "R11 blank addr max");
    read_chk(10'h155, 8'hFF, "R1 blank read");

    // R4 / R6 programming
    prog_pulse(5, 8'hA5, 1, 1); shadow[5] = 8'hA5;
    read_chk(5, 8'hA5, "R4 program A5");
    prog_pulse(5, 8'h5A, 2, 1); shadow[5] = 8'h00;
    read_chk(5, 8'h00, "R6 and-merge to 00");
    prog_pulse(6, 8'hF0, 1, 1);
    prog_pulse(6, 8'hFF, 1, 1); shadow[6] = 8'hF0;
    read_chk(6, 8'hF0, "R6 ones keep zeros");

    // R4 long strobe: only the final address/data applies, outputs undriven
    nxt(); idle(); vpp_on_oe = 1; vcc_hi = 1; oe_n = 0; addr = 9; din = 8'hF0;
    nxt(); ce_n = 0;
    repeat (3) nxt();
    #1 chk(dout_oe === 1'b0, "R4 undriven while programming", dout_oe, 0);
    addr = 7; din = 8'h0F;
    repeat (3) nxt();
    ce_n = 1;
    nxt(); idle(); shadow[7] = 8'h0F;
    read_chk(9, 8'hFF, "R4 no repeat write at earlier addr");
    read_chk(7, 8'h0F, "R4 single write on release");

    // R5 verify
    nxt(); idle(); vcc_hi = 1; ce_n = 0; oe_n = 0; addr = 5; #1;
    chk(dout_oe === 1'b1 && dout === 8'h00, "R5 verify addr 5", {dout_oe, dout}, 9'h100);
    addr = 6; #1;
    chk(dout_oe === 1'b1 && dout === 8'hF0, "R5 verify addr 6", {dout_oe, dout}, 9'h1F0);

    // R7 signature
    nxt(); idle(); a9_hv = 1; ce_n = 0; oe_n = 0; addr = 0; #1;
    chk(dout_oe === 1'b1 && dout === 8'h8F, "R7 maker code", {dout_oe, dout}, 9'h18F);
    addr = 1; #1;
    chk(dout_oe === 1'b1 && dout === 8'h85, "R7 device code", {dout_oe, dout}, 9'h185);

    // R10 illegal combinations
    addr = 3; #1;
    chk(dout_oe === 1'b0, "R10 signature with upper addr", dout_oe, 0);
    addr = 1; vcc_hi = 1; #1;
    chk(dout_oe === 1'b0 && dout === 8'h00, "R10 signature with raised supply", {dout_oe, dout}, 0);
    prog_pulse(8, 8'h00, 2, 0);
    read_chk(8, 8'hFF, "R10 strobe without raised supply");
    nxt(); idle(); vpp_on_oe = 1; vcc_hi = 1; a9_hv = 1; addr = 8; din = 8'h00;
    nxt(); ce_n = 0; nxt(); ce_n = 1; nxt(); idle();
    read_chk(8, 8'hFF, "R10 strobe with a9 high voltage");

    // R2 / R3
    nxt(); idle(); ce_n = 0; oe_n = 1; addr = 5; #1;
    chk(dout_oe === 1'b0, "R2 output disable", dout_oe, 0);
    ce_n = 1; oe_n = 0; #1;
    chk(dout_oe === 1'b0, "R3 standby with oe low", dout_oe, 0);

    // R8 / R9 erase
    begin
      int cyc = 0;
      nxt(); idle(); erase_req = 1;
      nxt(); erase_req = 0; ce_n = 0; oe_n = 0; addr = 5; #1;
      chk(erase_busy === 1'b1, "R8 busy raised", erase_busy, 1);
      chk(dout_oe === 1'b0, "R9 undriven while busy", dout_oe, 0);
      idle(); vpp_on_oe = 1; vcc_hi = 1; addr = 12; din = 8'h00;
      nxt(); ce_n = 0; cyc = 1;
      nxt(); ce_n = 1; erase_req = 1; cyc++;
      nxt(); idle(); cyc++;
      while (erase_busy === 1'b1 && cyc < 4 * NCYC) begin
        nxt(); cyc++;
      end
      chk(cyc == NCYC, "R8 sweep length", cyc, NCYC);
      chk(cyc == NCYC, "R9 request during sweep ignored", cyc, NCYC);
      for (int i = 0; i < DEPTH; i++) shadow[i] = 8'hFF;
      read_chk(5, 8'hFF, "R8 addr 5 blank");
      read_chk(7, 8'hFF, "R8 addr 7 blank");
      read_chk(12, 8'hFF, "R9 busy strobe ignored");
    end

    // Random mode sequence against shadow model
    begin
      int unsigned seed = $urandom(32'd20240611);
      bit pp = 0;
      logic [AW-1:0] pa = '0;
      logic [7:0] pd = '0;
      for (int it = 0; it < 3000; it++) begin
        bit c, o, vp, vh, hv, drv, fire;
        logic [AW-1:0] a;
        logic [7:0] d, eb;
        nxt();
        c  = ($urandom % 2) == 0;
        o  = ($urandom % 10) < 3;
        vp = ($urandom % 4) == 0;
        vh = ($urandom % 20) < 7;
        hv = ($urandom % 20) < 3;
        a  = (($urandom % 2) == 0) ? AW'($urandom % 4) : AW'($urandom);
        d  = 8'($urandom);
        ce_n = c; oe_n = o; vpp_on_oe = vp; vcc_hi = vh; a9_hv = hv; addr = a; din = d;
        #1;
        drv = exp_drive(c, o, vp, vh, hv, a);
        eb  = drv ? exp_byte(hv, a) : 8'h00;
        chk(dout_oe === drv && dout === eb, "R1/R5/R7/R10/R12 random mode map",
            {dout_oe, dout}, {drv, eb});
        fire = pp && vp && vh && c && !hv;
        if (fire) shadow[pa] = shadow[pa] & pd;
        pp = vp && vh && !c && !hv;
        pa = a; pd = d;
      end
      if (seed == 0) n_run += 0;
    end
    nxt(); idle();
    nxt();
    for (int i = 0; i < DEPTH; i++) begin
      addr = AW'(i); ce_n = 0; oe_n = 0; #1;
      chk(dout === shadow[i], "R6 random programming contents", dout, shadow[i]);
    end

    // R8 full blank after second erase
    nxt(); idle(); erase_req = 1;
    nxt(); erase_req = 0;
    while (erase_busy === 1'b1) nxt();
    begin
      int bad = 0;
      for (int i = 0; i < DEPTH; i++) begin
        addr = AW'(i); ce_n = 0; oe_n = 0; #1;
        if (dout !== 8'hFF) bad++;
      end
      chk(bad == 0, "R8 full array blank", bad, 0);
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule